// File: doc/BRIEF.md
# External Trigger Conditioner

This block takes an asynchronous trigger pin from outside the chip and turns it into count-enable pulses for a timer counter running on the master clock. The pin is first resynchronised to the master clock. An optional inversion then selects which pin edge is active. A power-of-two prescaler can divide the edge rate by 1, 2, 4 or 8, so that a fast external clock falls to a rate the master clock can sample safely.

The prescaled signal leaves the block on `presc_out` and goes to a separate digital filter. The filtered result returns on `filt_in`. An edge detector turns each rising edge of the filtered signal into a single-cycle pulse on `cnt_en`. This happens only while the external-clock enable is set.

When the external-clock enable is clear, the block can instead pass on a one-cycle tick produced by the timer's trigger-input clock mode. When both sources are enabled, the filtered external trigger takes priority.

Top module: `etrig_conditioner`

## Requirements
- R1: The pin passes through a two-flop synchroniser before any other logic. With the divide code at 00, `presc_out` takes the pin level (after polarity) three clock edges after the edge that first samples the pin. The matching `cnt_en` pulse appears on the fourth edge.
- R2: With `cfg_invert` = 0 the pin passes unchanged, so its rising edge is the active edge. With `cfg_invert` = 1 the pin is inverted, so its falling edge is the active edge and its rising edge produces no count.
- R3: `cfg_div` selects the division: 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8. For divide-by-N with N > 1, `presc_out` starts low after reset and toggles after every N/2 active edges. It therefore rises once per N active edges with a 50% duty cycle.
- R4: While `cfg_ext_en` = 1, each rising edge of `filt_in` produces exactly one `cnt_en` pulse, one cycle wide, on the next clock edge.
- R5: With `cfg_ext_en` = 0 and `cfg_trgi_en` = 0, `cnt_en` stays low whatever the pin and `trgi_tick` do.
- R6: With `cfg_ext_en` = 0 and `cfg_trgi_en` = 1, `cnt_en` repeats `trgi_tick` one clock later, cycle for cycle.
- R7: With both `cfg_ext_en` and `cfg_trgi_en` set, `trgi_tick` is ignored and only rising edges of `filt_in` produce pulses.
- R8: Any change of `cfg_div` clears the prescaler's edge counter, so no partial count carries over to the new ratio.
- R9: After reset, `presc_out` and `cnt_en` are 0.
- R10: While the pin holds each level for at least two master cycles and the configuration is steady, `presc_out` holds each level for at least two cycles, which is no faster than a quarter of the master rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pin | input | 1 | Raw asynchronous trigger pin |
| cfg_invert | input | 1 | 1 selects the falling pin edge as the active edge |
| cfg_div | input | 2 | Edge-rate divide code: 00 /1, 01 /2, 10 /4, 11 /8 |
| cfg_ext_en | input | 1 | Count on rising edges of the filtered trigger |
| cfg_trgi_en | input | 1 | Pass on trigger-input clock ticks when cfg_ext_en is 0 |
| trgi_tick | input | 1 | One-cycle tick from the trigger-input clock mode |
| filt_in | input | 1 | Filtered trigger returned by the external filter |
| presc_out | output | 1 | Polarity-corrected, prescaled trigger sent to the filter |
| cnt_en | output | 1 | One-cycle count-enable pulse |

## Verification
The bench runs random trials over all four divide codes and both polarities. Each trial counts the prescaler's rising edges and the count-enable pulses, and compares them with the number the division rule predicts. A prescaler off by one in its reload, or counting the wrong pin edge, would report too many or too few edges. Directed cases pin the exact pipeline latency, where a missing or extra synchroniser stage would shift the pulse by a cycle. They also change the divide code after a partial count: a counter that is not cleared would toggle one edge early. Finally, they show the trigger-input tick passing through only when the external path is off and being dropped when both sources are enabled. A wrong priority there would produce extra pulses.

// File: rtl/etc_pkg.sv
package etc_pkg;

  // Width of the divide-code field and the codes themselves.
  localparam int DIV_SEL_W = 2;

  typedef enum logic [DIV_SEL_W-1:0] {
    DIV_1 = 2'd0,
    DIV_2 = 2'd1,
    DIV_4 = 2'd2,
    DIV_8 = 2'd3
  } div_sel_e;

  // The largest division is 2**(2**DIV_SEL_W - 1).
  // The output toggles every half of that count.
  localparam int MAX_HALF = 1 << ((1 << DIV_SEL_W) - 2);
  localparam int EDGE_CNT_W = $clog2(MAX_HALF);

endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  // Shift the pin in at bit 0; the oldest stage is the output.
  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_n = async_in;
    end else begin : g_multi
      always_comb chain_n = {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/etc_presc.sv
module etc_presc
  import etc_pkg::*;
#(
  parameter int CNT_W = EDGE_CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_in,
  input  logic                 cfg_invert,
  input  logic [DIV_SEL_W-1:0] cfg_div,
  output logic                 presc_out
);

  div_sel_e   div_sel;
  div_sel_e   div_q;
  logic       sync_d_q;
  logic       pol;
  logic       active;
  logic       div_chg;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic       out_q, out_n;

  assign div_sel = div_sel_e'(cfg_div);
  assign pol     = sync_in ^ cfg_invert;

  // The active edge is taken from the raw synchronised level so that a
  // polarity change alone never registers as an edge.
  assign active  = cfg_invert ? (sync_d_q & ~sync_in) : (sync_in & ~sync_d_q);
  assign div_chg = (div_q != div_sel);

  // Terminal count: toggle after half the division ratio of active edges.
  always_comb begin
    case (div_sel)
      DIV_4:   limit = CNT_W'(1);
      DIV_8:   limit = CNT_W'(3);
      default: limit = '0;
    endcase
  end

  always_comb begin
    cnt_n = cnt_q;
    out_n = out_q;
    if (div_sel == DIV_1) begin
      cnt_n = '0;
      out_n = pol;
    end else if (div_chg) begin
      cnt_n = '0;
    end else if (active) begin
      if (cnt_q == limit) begin
        cnt_n = '0;
        out_n = ~out_q;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d_q <= 1'b0;
      div_q    <= DIV_1;
      cnt_q    <= '0;
      out_q    <= 1'b0;
    end else begin
      sync_d_q <= sync_in;
      div_q    <= div_sel;
      cnt_q    <= cnt_n;
      out_q    <= out_n;
    end
  end

  assign presc_out = out_q;

  // R3: in a divided mode the output only moves on an active edge.
  p_div_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_q) == $past(div_sel) && $past(div_sel) != DIV_1 &&
     out_q != $past(out_q)) |-> $past(active));

  // R8: after a divide-code change the next active edge cannot toggle
  // unless the new limit is zero.
  p_clear_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_chg && div_sel != DIV_1) |=>
      (out_q == $past(out_q) || $past(div_sel) != div_sel));

  // R10: with a steady configuration, a level lasts at least two cycles.
  p_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out_q) && $stable(cfg_div) && $stable(cfg_invert)) |=>
      ($stable(out_q) || !$stable(cfg_div) || !$stable(cfg_invert)));

endmodule

// File: rtl/etc_edge.sv
module etc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_in,
  input  logic cfg_ext_en,
  input  logic cfg_trgi_en,
  input  logic trgi_tick,
  output logic cnt_en
);

  logic filt_d_q;
  logic rise;
  logic pulse_n, pulse_q;
  logic live_q;

  assign rise = filt_in & ~filt_d_q;

  // The filtered external trigger wins whenever it is enabled.
  always_comb begin
    if (cfg_ext_en)       pulse_n = rise;
    else if (cfg_trgi_en) pulse_n = trgi_tick;
    else                  pulse_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_d_q <= 1'b0;
      pulse_q  <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      filt_d_q <= filt_in;
      pulse_q  <= pulse_n;
      live_q   <= 1'b1;
    end
  end

  assign cnt_en = pulse_q;

  // R4: an external-sourced pulse follows a high filtered input.
  p_ext_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && $past(cfg_ext_en)) |-> $past(filt_in));

  // R5: with both sources off there is no pulse.
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(cfg_ext_en) && !$past(cfg_trgi_en)) |-> !cnt_en);

  // R6: the trigger-input tick is repeated one cycle later.
  p_trgi_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(cfg_ext_en) && $past(cfg_trgi_en)) |->
      (cnt_en == $past(trgi_tick)));

endmodule

// File: rtl/etrig_conditioner.sv
module etrig_conditioner
  import etc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_pin,
  input  logic       cfg_invert,
  input  logic [1:0] cfg_div,
  input  logic       cfg_ext_en,
  input  logic       cfg_trgi_en,
  input  logic       trgi_tick,
  input  logic       filt_in,
  output logic       presc_out,
  output logic       cnt_en
);

  localparam int LAT = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(LAT + 1);

  logic pin_sync;
  logic [WARM_W-1:0] warm_q, warm_n;

  etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_pin),
    .sync_out (pin_sync)
  );

  etc_presc u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_in    (pin_sync),
    .cfg_invert (cfg_invert),
    .cfg_div    (cfg_div),
    .presc_out  (presc_out)
  );

  etc_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .filt_in     (filt_in),
    .cfg_ext_en  (cfg_ext_en),
    .cfg_trgi_en (cfg_trgi_en),
    .trgi_tick   (trgi_tick),
    .cnt_en      (cnt_en)
  );

  // Cycles since reset, saturating once the pipeline holds only live data.
  always_comb begin
    warm_n = warm_q;
    if (warm_q != WARM_W'(LAT)) warm_n = warm_q + WARM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= warm_n;
  end

  // R1: in divide-by-1 mode the output is the pin, delayed through the
  // synchroniser and the output register, with polarity applied.
  p_div1_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == WARM_W'(LAT) && $past(cfg_div) == 2'd0) |->
      (presc_out == ($past(trig_pin, 3) ^ $past(cfg_invert))));

endmodule

// File: tb/etrig_conditioner_tb.sv
module etrig_conditioner_tb;

  logic       clk;
  logic       rst_n;
  logic       trig_pin;
  logic       cfg_invert;
  logic [1:0] cfg_div;
  logic       cfg_ext_en;
  logic       cfg_trgi_en;
  logic       trgi_tick;
  logic       presc_out;
  logic       cnt_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Filter bypassed: the prescaled signal returns straight to the detector.
  etrig_conditioner u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_pin    (trig_pin),
    .cfg_invert  (cfg_invert),
    .cfg_div     (cfg_div),
    .cfg_ext_en  (cfg_ext_en),
    .cfg_trgi_en (cfg_trgi_en),
    .trgi_tick   (trgi_tick),
    .filt_in     (presc_out),
    .presc_out   (presc_out),
    .cnt_en      (cnt_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Monitor, sampling on the falling edge.
  bit mon_en = 0;
  int pulse_cnt, rise_cnt, run_len, min_run;
  bit prev_presc, run_valid;

  always @(negedge clk) begin
    if (mon_en) begin
      if (cnt_en) pulse_cnt++;
      if (presc_out && !prev_presc) rise_cnt++;
      if (presc_out == prev_presc) run_len++;
      else begin
        if (run_valid && run_len < min_run) min_run = run_len;
        run_valid = 1;
        run_len = 1;
      end
    end
    prev_presc = presc_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rises(input logic [1:0] div, input int edges);
    int half;
    int toggles;
    if (div == 2'd0) return edges;
    half = 1 << (div - 1);
    toggles = edges / half;
    return (toggles + 1) / 2;
  endfunction

  task automatic clr_counts();
    pulse_cnt = 0;
    rise_cnt  = 0;
    run_len   = 0;
    run_valid = 0;
    min_run   = 1000;
  endtask

  task automatic do_reset(input bit inv, input logic [1:0] div,
                          input bit ext, input bit trgi);
    mon_en      = 0;
    cfg_invert  = inv;
    cfg_div     = div;
    cfg_ext_en  = ext;
    cfg_trgi_en = trgi;
    trgi_tick   = 0;
    trig_pin    = inv;
    rst_n       = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // One active edge: go to the active level, hold, return to idle, hold.
  task automatic pin_edge(input int ha, input int hb, input bit noise);
    trig_pin = ~cfg_invert;
    for (int i = 0; i < ha; i++) begin
      if (noise) trgi_tick = 1'($urandom % 2);
      @(negedge clk);
    end
    trig_pin = cfg_invert;
    for (int i = 0; i < hb; i++) begin
      if (noise) trgi_tick = 1'($urandom % 2);
      @(negedge clk);
    end
    trgi_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c1e));

    // R9: reset state; R1: exact pipeline latency.
    do_reset(0, 2'd0, 1, 0);
    @(negedge clk);
    check(presc_out == 0, "R9 presc_out after reset", presc_out, 0);
    check(cnt_en == 0, "R9 cnt_en after reset", cnt_en, 0);
    repeat (4) @(negedge clk);
    trig_pin = 1;
    @(negedge clk);
    @(negedge clk);
    check(presc_out == 0, "R1 presc_out before third edge", presc_out, 0);
    @(negedge clk);
    check(presc_out == 1, "R1 presc_out on third edge", presc_out, 1);
    check(cnt_en == 0, "R1 cnt_en not yet", cnt_en, 0);
    @(negedge clk);
    check(cnt_en == 1, "R1 R4 cnt_en on fourth edge", cnt_en, 1);
    @(negedge clk);
    check(cnt_en == 0, "R4 pulse one cycle wide", cnt_en, 0);

    // R2: inverted polarity counts falling pin edges only.
    do_reset(1, 2'd0, 0, 0);
    repeat (8) @(negedge clk);
    cfg_ext_en = 1;
    clr_counts();
    mon_en = 1;
    trig_pin = 0;
    repeat (8) @(negedge clk);
    check(pulse_cnt == 1, "R2 falling edge counted", pulse_cnt, 1);
    trig_pin = 1;
    repeat (8) @(negedge clk);
    check(pulse_cnt == 1, "R2 rising edge ignored", pulse_cnt, 1);

    // R5: both sources disabled.
    do_reset(0, 2'd0, 0, 0);
    repeat (8) @(negedge clk);
    clr_counts();
    mon_en = 1;
    for (int k = 0; k < 4; k++) pin_edge(3, 3, 1);
    trgi_tick = 1;
    repeat (3) @(negedge clk);
    trgi_tick = 0;
    repeat (6) @(negedge clk);
    check(pulse_cnt == 0, "R5 no pulses while disabled", pulse_cnt, 0);

    // R6: trigger-input ticks pass through one cycle later.
    do_reset(0, 2'd0, 0, 1);
    repeat (8) @(negedge clk);
    trgi_tick = 1;
    @(negedge clk);
    trgi_tick = 0;
    check(cnt_en == 1, "R6 tick repeated next cycle", cnt_en, 1);
    @(negedge clk);
    check(cnt_en == 0, "R6 tick ends", cnt_en, 0);
    clr_counts();
    mon_en = 1;
    trgi_tick = 1;
    repeat (3) @(negedge clk);
    trgi_tick = 0;
    repeat (4) @(negedge clk);
    check(pulse_cnt == 3, "R6 back-to-back ticks", pulse_cnt, 3);

    // R8: a divide-code change discards the partial count.
    do_reset(0, 2'd3, 1, 0);
    repeat (8) @(negedge clk);
    pin_edge(3, 4, 0);
    cfg_div = 2'd2;
    repeat (4) @(negedge clk);
    pin_edge(3, 4, 0);
    check(presc_out == 0, "R8 counter cleared on code change", presc_out, 0);
    pin_edge(3, 4, 0);
    check(presc_out == 1, "R8 toggle after two edges at new ratio", presc_out, 1);

    // Random trials: R3 division, R4 pulses, R7 priority, R10 rate.
    for (int t = 0; t < 48; t++) begin
      logic [1:0] div;
      bit inv, noise;
      int edges;
      div   = 2'($urandom % 4);
      inv   = 1'($urandom % 2);
      noise = 1'($urandom % 2);
      edges = 1 + int'($urandom % 20);
      if (t < 4) begin
        div = 2'(t);
        edges = 17;
      end
      do_reset(inv, div, 0, noise);
      repeat (8) @(negedge clk);
      cfg_ext_en = 1;
      clr_counts();
      mon_en = 1;
      for (int k = 0; k < edges; k++)
        pin_edge(2 + int'($urandom % 4), 2 + int'($urandom % 4), noise);
      repeat (12) @(negedge clk);
      mon_en = 0;
      check(rise_cnt == exp_rises(div, edges), "R3 prescaled rising edges",
            rise_cnt, exp_rises(div, edges));
      check(pulse_cnt == exp_rises(div, edges),
            noise ? "R7 pulses with tick noise ignored" : "R4 pulse count",
            pulse_cnt, exp_rises(div, edges));
    end
    check(min_run >= 2 || min_run == 1000, "R10 minimum level length", min_run, 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule